// File: doc/BRIEF.md
# Supply Monitor Status and Control Register

This block is a byte-wide, memory-mapped register for supply supervision in a small microcontroller. Two comparator outputs come in from the analog side. The detect input means the supply is below the reset trip level, and the warning input means it is below the earlier warning level. The register holds three controls: a master enable for low-supply detection, an enable that turns a detect event into a system reset, and an enable that keeps detection alive in stop mode. It also holds two trip-level select bits that feed the trip generator.

A sticky warning flag records that the warning level was crossed. Software clears it by writing a one to a write-only acknowledge bit. That clear takes effect only once the supply has recovered above the warning level. Both comparator inputs pass through a two-flop synchroniser before they act.

The reset request is latched and stays high until the system reset arrives. During reset a cause code says what kind of reset is in progress. That code decides whether the trip-level selects are reinitialised.

Top module: `supply_mon_reg`

## Requirements
- R1: When the detect enable (bit 3) is 0, `det_active` is 0 and no detect event raises `rst_req`.
- R2: When the detect enable and the reset enable (bit 2) are both 1 and `det_in` is high, `rst_req` rises on the third rising clock edge after `det_in` rises. It then stays high, even after `det_in` falls, until `rst_n` is asserted.
- R3: In stop mode (`stop_mode`=1), detection stays active only when the stop enable (bit 1) is 1. With the stop enable at 0, `det_active` is 0 and no reset request is raised.
- R4: The warning flag (bit 7) sets on the third rising edge after `warn_in` goes high. It also sets when `warn_in` is already high as reset is released.
- R5: Writing 1 to the acknowledge bit (bit 6) clears the warning flag only while the synchronised `warn_in` is low. Otherwise the flag stays 1. Writing 0 to bit 6 has no effect.
- R6: Once set, the warning flag stays 1 after `warn_in` falls, until it is acknowledged.
- R7: Read layout: bit 7 is the flag, bit 6 always reads 0, bit 5 is the detect-level select, bit 4 is the warning-level select, bits 3, 2 and 1 are the detect, reset and stop enables, and bit 0 reads 0. Writes to bit 7 are ignored.
- R8: The two level selects (bits 5 and 4) clear only when `rst_kind` is 2'b01 (power-on) during reset. With 2'b10 (low-voltage) or any other code they keep their values.
- R9: Any reset leaves the flag at 0, the detect and reset enables at 1 and the stop enable at 0, so a read after reset with cleared selects gives 8'h0C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| rst_kind | input | 2 | Reset cause while `rst_n` is low: 01 power-on, 10 low-voltage, other codes other |
| det_in | input | 1 | Comparator: supply below the detect level (asynchronous) |
| warn_in | input | 1 | Comparator: supply below the warning level (asynchronous) |
| stop_mode | input | 1 | High while the chip is in stop mode |
| bus_wr | input | 1 | Write strobe for the register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| rst_req | output | 1 | Latched system reset request |
| det_active | output | 1 | Detect logic currently enabled |
| det_lvl_sel | output | 1 | Detect trip-level select |
| warn_lvl_sel | output | 1 | Warning trip-level select |

## Verification
Read data and `det_active` follow the register state with no delay. A write therefore shows on `bus_rdata` at the falling edge right after the rising edge that takes it. A comparator change reaches the flag and `rst_req` on the third rising edge: two synchroniser stages, then the state register. For R2 and R4 the bench samples at the falling edges after the second and the third rising edge, expecting no change at the first sample and the change at the second. Every other check waits at least four edges after a comparator change, so that the synchronised value has settled before an acknowledge or a read.

// File: rtl/supply_mon_reg.sv
module supply_mon_reg #(
  parameter int SYNC_STAGES = 2,
  parameter logic [1:0] KIND_POR = 2'b01
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rst_kind,
  input  logic       det_in,
  input  logic       warn_in,
  input  logic       stop_mode,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       rst_req,
  output logic       det_active,
  output logic       det_lvl_sel,
  output logic       warn_lvl_sel
);
  logic [SYNC_STAGES-1:0] det_sync, warn_sync;
  logic det_s, warn_s;
  logic flag, det_en, rst_en, stop_en;
  logic ack_wr, fire;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      det_sync  <= '0;
      warn_sync <= '0;
    end else begin
      det_sync  <= {det_sync[SYNC_STAGES-2:0], det_in};
      warn_sync <= {warn_sync[SYNC_STAGES-2:0], warn_in};
    end

  assign det_s  = det_sync[SYNC_STAGES-1];
  assign warn_s = warn_sync[SYNC_STAGES-1];

  assign det_active = det_en && (!stop_mode || stop_en);
  assign fire       = det_active && rst_en && det_s;
  assign ack_wr     = bus_wr && bus_wdata[6];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flag    <= 1'b0;
      det_en  <= 1'b1;
      rst_en  <= 1'b1;
      stop_en <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= rst_req || fire;
      if (warn_s)      flag <= 1'b1;
      else if (ack_wr) flag <= 1'b0;
      if (bus_wr) begin
        det_en  <= bus_wdata[3];
        rst_en  <= bus_wdata[2];
        stop_en <= bus_wdata[1];
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      if (rst_kind == KIND_POR) begin
        det_lvl_sel  <= 1'b0;
        warn_lvl_sel <= 1'b0;
      end
    end else if (bus_wr) begin
      det_lvl_sel  <= bus_wdata[5];
      warn_lvl_sel <= bus_wdata[4];
    end

  assign bus_rdata = {flag, 1'b0, det_lvl_sel, warn_lvl_sel, det_en, rst_en, stop_en, 1'b0};

  a_r2_request_raised: assert property (@(posedge clk) disable iff (!rst_n)
    (det_en && rst_en && det_s && (!stop_mode || stop_en)) |=> rst_req);
  a_r2_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);
  a_r1_request_needs_enables: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(det_en && rst_en));
  a_r5_ack_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    warn_s |=> bus_rdata[7]);
  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata[7] && !(bus_wr && bus_wdata[6])) |=> bus_rdata[7]);
  a_r3_stop_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_mode && !stop_en) |-> !det_active);
endmodule

// File: tb/supply_mon_reg_tb.sv
module supply_mon_reg_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] rst_kind = 2'b01;
  logic det_in = 1'b0, warn_in = 1'b0, stop_mode = 1'b0;
  logic bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic rst_req, det_active, det_lvl_sel, warn_lvl_sel;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  supply_mon_reg u_dut (
    .clk(clk), .rst_n(rst_n), .rst_kind(rst_kind), .det_in(det_in),
    .warn_in(warn_in), .stop_mode(stop_mode), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req),
    .det_active(det_active), .det_lvl_sel(det_lvl_sel), .warn_lvl_sel(warn_lvl_sel)
  );

  typedef struct packed {
    logic       warn;
    logic       wr;
    logic [7:0] wd;
    logic [7:0] exp;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 8'h00, 8'h0C},
    '{1'b1, 1'b0, 8'h00, 8'h8C},
    '{1'b0, 1'b0, 8'h00, 8'h8C},
    '{1'b1, 1'b1, 8'h4C, 8'h8C},
    '{1'b0, 1'b1, 8'h0C, 8'h8C},
    '{1'b0, 1'b1, 8'h4C, 8'h0C},
    '{1'b0, 1'b1, 8'hBF, 8'h3E},
    '{1'b0, 1'b1, 8'h0C, 8'h0C}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1;
    bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    bus_wdata = 8'h00;
  endtask

  task automatic do_reset(input logic [1:0] kind);
    @(negedge clk);
    rst_kind = kind;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rst_kind = 2'b00;
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_edges(2);
    rst_n = 1'b1;
    rst_kind = 2'b00;
    wait_edges(1);
    check("R9 reset value", bus_rdata, 8'h0C);
    check("R9 no request", {7'd0, rst_req}, 8'd0);
    check("R9 det_active", {7'd0, det_active}, 8'd1);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      warn_in = VECS[i].warn;
      wait_edges(4);
      if (VECS[i].wr) write_reg(VECS[i].wd);
      check($sformatf("R4/R5/R6/R7 vector %0d", i), bus_rdata, VECS[i].exp);
    end

    write_reg(8'h3C);
    do_reset(2'b10);
    check("R8 low-voltage reset keeps selects", bus_rdata, 8'h3C);
    write_reg(8'h30);
    do_reset(2'b00);
    check("R8 other reset keeps selects", bus_rdata, 8'h3C);
    check("R8 select pins", {6'd0, det_lvl_sel, warn_lvl_sel}, 8'h03);
    do_reset(2'b01);
    check("R8 power-on reset clears selects", bus_rdata, 8'h0C);

    @(negedge clk);
    rst_kind = 2'b00;
    rst_n = 1'b0;
    warn_in = 1'b1;
    wait_edges(2);
    rst_n = 1'b1;
    wait_edges(2);
    check("R4 flag not yet at edge 2", bus_rdata & 8'h80, 8'h00);
    wait_edges(1);
    check("R4 flag set out of reset", bus_rdata & 8'h80, 8'h80);
    warn_in = 1'b0;
    wait_edges(4);
    write_reg(8'h4C);

    det_in = 1'b1;
    wait_edges(2);
    check("R2 request not yet at edge 2", {7'd0, rst_req}, 8'd0);
    wait_edges(1);
    check("R2 request at edge 3", {7'd0, rst_req}, 8'd1);
    det_in = 1'b0;
    wait_edges(5);
    check("R2 request held", {7'd0, rst_req}, 8'd1);
    do_reset(2'b10);
    check("R2 request cleared by reset", {7'd0, rst_req}, 8'd0);

    write_reg(8'h04);
    det_in = 1'b1;
    wait_edges(5);
    check("R1 no request when disabled", {7'd0, rst_req}, 8'd0);
    check("R1 det_active low", {7'd0, det_active}, 8'd0);
    det_in = 1'b0;
    wait_edges(4);

    write_reg(8'h0C);
    stop_mode = 1'b1;
    det_in = 1'b1;
    wait_edges(5);
    check("R3 stop disables detect", {6'd0, det_active, rst_req}, 8'd0);
    write_reg(8'h0E);
    wait_edges(1);
    check("R3 stop enable keeps detect", {6'd0, det_active, rst_req}, 8'd3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule